// File: doc/BRIEF.md
# Line-Region Clamp and Blanking Pulse Generator

This block produces three per-pixel timing pulses for an image-sensor readout: an optical-black clamp, a dummy-pixel clamp and a pixel blanking pulse. A pixel counter restarts on every line sync, and a line counter restarts on every field sync. Four waveform sequences are stored. Each sequence is a resting level plus a window that opens at one pixel position and closes at a second. Inside the window the output takes the opposite of the resting level.

A field is cut into up to four line regions. Region 0 always starts at line 0, and the starting lines of regions 1 to 3 are programmable. Within each region, a pointer per output names the sequence that output follows. The two clamp outputs share one set of region boundaries, and the blanking output has its own boundaries and pointers. A simple synchronous write port loads all settings.

Top module: `clamp_seq_gen`

## Requirements
- R1: `hsync_i` or `vsync_i` high at a clock edge sets the pixel count to 0. Otherwise the pixel count rises by 1 per clock and holds at its maximum, 2^PIX_W-1.
- R2: `vsync_i` high at a clock edge sets the line count to 0. `hsync_i` high without `vsync_i` adds 1 to the line count, which holds at its maximum.
- R3: For the selected sequence, with resting level p, first position a and second position b, the output is ~p when a <= pixel < b and p otherwise. Each output is registered, so it shows the value for pixel count n one clock after the counter holds n.
- R4: If a is beyond the last pixel of the line, or if b <= a, the output stays at p for the whole line.
- R5: The active region is the highest k in 1..3 whose boundary line is <= the current line. If there is no such k, region 0 is active. Boundaries are assumed to be in ascending order.
- R6: Both clamp outputs select their region from the clamp boundary set. The blanking output selects its region from the blanking boundary set only.
- R7: In a clamp pointer word, bits [1:0] choose the optical-black clamp sequence and bits [3:2] choose the dummy clamp sequence. In a blanking pointer word, bits [1:0] choose the sequence. Each output may follow a different sequence in the same region.
- R8: On a write, address bits [4:2] select the kind of setting and bits [1:0] select the index:
  - 0: first position, data [11:0].
  - 1: second position, data [11:0].
  - 2: resting level, data bit 0.
  - 3: clamp boundary line.
  - 4: blanking boundary line.
  - 5: clamp pointer word.
  - 6: blanking pointer word.
- R9: After reset all outputs are low. All positions, levels, boundaries and pointers are 0, so every output stays low until it is configured.
- R10: A write with kind 7, or to boundary index 0, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Line start pulse |
| vsync_i | input | 1 | Field start pulse |
| cfg_we_i | input | 1 | Setting write strobe |
| cfg_addr_i | input | 5 | Setting address: kind and index |
| cfg_wdata_i | input | 12 | Setting data |
| ob_clamp_o | output | 1 | Optical-black clamp pulse |
| dummy_clamp_o | output | 1 | Dummy-pixel clamp pulse |
| pix_blank_o | output | 1 | Pixel blanking pulse |

## Verification
The bench builds the block with its default parameters: 12-bit pixel and line counters, four sequences and four regions. The 12-bit pixel counter lets one long line of about 4100 clocks reach the saturation point. With short lines of around 20 pixels, a first position of 4000 lies well beyond the end of a line, which tests R4. Short lines also let a full field cross all region boundaries in a few hundred clocks.

// File: rtl/clamp_seq_pkg.sv
package clamp_seq_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_T1   = 3'd0,
    KIND_T2   = 3'd1,
    KIND_POL  = 3'd2,
    KIND_CCP  = 3'd3,
    KIND_BCP  = 3'd4,
    KIND_CPTR = 3'd5,
    KIND_BPTR = 3'd6,
    KIND_NONE = 3'd7
  } cfg_kind_e;
endpackage

// File: rtl/pix_line_cnt.sv
module pix_line_cnt #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o <= '0;
    end else if (hsync_i || vsync_i) begin
      pix_o <= '0;
    end else if (pix_o != PIX_MAX) begin
      pix_o <= pix_o + PIX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_o <= '0;
    end else if (vsync_i) begin
      line_o <= '0;
    end else if (hsync_i && line_o != LINE_MAX) begin
      line_o <= line_o + LINE_W'(1);
    end
  end

  AST_PIX_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i || vsync_i) |=> pix_o == '0); // R1
  AST_PIX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsync_i && !vsync_i && pix_o != PIX_MAX) |=> pix_o == $past(pix_o) + PIX_W'(1)); // R1
  AST_PIX_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsync_i && !vsync_i && pix_o == PIX_MAX) |=> pix_o == PIX_MAX); // R1
  AST_LINE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |=> line_o == '0); // R2
  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i && !vsync_i && line_o != LINE_MAX) |=> line_o == $past(line_o) + LINE_W'(1)); // R2
endmodule

// File: rtl/seq_cfg_regs.sv
module seq_cfg_regs
  import clamp_seq_pkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int LINE_W  = 12,
  parameter int NUM_SEQ = 4,
  parameter int NUM_RGN = 4,
  parameter int IDX_W   = 2,
  parameter int SEL_W   = 2,
  parameter int DATA_W  = 12
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic [KIND_W+IDX_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]                    wdata_i,
  output logic [NUM_SEQ-1:0][PIX_W-1:0]        t1_o,
  output logic [NUM_SEQ-1:0][PIX_W-1:0]        t2_o,
  output logic [NUM_SEQ-1:0]                   pol_o,
  output logic [NUM_RGN-1:1][LINE_W-1:0]       ccp_o,
  output logic [NUM_RGN-1:1][LINE_W-1:0]       bcp_o,
  output logic [NUM_RGN-1:0][SEL_W-1:0]        ob_ptr_o,
  output logic [NUM_RGN-1:0][SEL_W-1:0]        dm_ptr_o,
  output logic [NUM_RGN-1:0][SEL_W-1:0]        bl_ptr_o
);
  cfg_kind_e        kind;
  logic [IDX_W-1:0] idx;

  assign kind = cfg_kind_e'(addr_i[KIND_W+IDX_W-1:IDX_W]);
  assign idx  = addr_i[IDX_W-1:0];

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        t1_o[s]  <= '0;
        t2_o[s]  <= '0;
        pol_o[s] <= 1'b0;
      end else if (we_i && idx == IDX_W'(s)) begin
        if (kind == KIND_T1)  t1_o[s]  <= wdata_i[PIX_W-1:0];
        if (kind == KIND_T2)  t2_o[s]  <= wdata_i[PIX_W-1:0];
        if (kind == KIND_POL) pol_o[s] <= wdata_i[0];
      end
    end
  end

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ob_ptr_o[r] <= '0;
        dm_ptr_o[r] <= '0;
        bl_ptr_o[r] <= '0;
      end else if (we_i && idx == IDX_W'(r)) begin
        if (kind == KIND_CPTR) begin
          ob_ptr_o[r] <= wdata_i[SEL_W-1:0];
          dm_ptr_o[r] <= wdata_i[2*SEL_W-1:SEL_W];
        end
        if (kind == KIND_BPTR) bl_ptr_o[r] <= wdata_i[SEL_W-1:0];
      end
    end

    // boundary 0 is pinned to line 0 and has no storage
    if (r > 0) begin : g_cp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ccp_o[r] <= '0;
          bcp_o[r] <= '0;
        end else if (we_i && idx == IDX_W'(r)) begin
          if (kind == KIND_CCP) ccp_o[r] <= wdata_i[LINE_W-1:0];
          if (kind == KIND_BCP) bcp_o[r] <= wdata_i[LINE_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/region_select.sv
module region_select #(
  parameter int LINE_W  = 12,
  parameter int NUM_RGN = 4,
  parameter int RGN_W   = 2
) (
  input  logic [LINE_W-1:0]                line_i,
  input  logic [NUM_RGN-1:1][LINE_W-1:0]   cp_i,
  output logic [RGN_W-1:0]                 rgn_o
);
  // ascending boundaries assumed: last passed boundary wins
  always_comb begin
    rgn_o = '0;
    for (int k = 1; k < NUM_RGN; k++) begin
      if (line_i >= cp_i[k]) rgn_o = RGN_W'(k);
    end
  end
endmodule

// File: rtl/seq_pulse.sv
module seq_pulse #(
  parameter int PIX_W   = 12,
  parameter int NUM_SEQ = 4,
  parameter int NUM_RGN = 4,
  parameter int SEL_W   = 2,
  parameter int RGN_W   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [PIX_W-1:0]              pix_i,
  input  logic [RGN_W-1:0]              rgn_i,
  input  logic [NUM_RGN-1:0][SEL_W-1:0] ptr_i,
  input  logic [NUM_SEQ-1:0][PIX_W-1:0] t1_i,
  input  logic [NUM_SEQ-1:0][PIX_W-1:0] t2_i,
  input  logic [NUM_SEQ-1:0]            pol_i,
  output logic                          pulse_o
);
  logic [SEL_W-1:0] sel;
  logic             in_win;
  logic             level;

  assign sel    = ptr_i[rgn_i];
  assign in_win = (pix_i >= t1_i[sel]) && (pix_i < t2_i[sel]);
  assign level  = pol_i[sel] ^ in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= level;
  end

  AST_REST_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_i < t1_i[sel] || pix_i >= t2_i[sel]) |=> pulse_o == $past(pol_i[sel])); // R3
  AST_WIN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_i >= t1_i[sel] && pix_i < t2_i[sel]) |=> pulse_o != $past(pol_i[sel])); // R3
  AST_EMPTY_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t2_i[sel] <= t1_i[sel]) |=> pulse_o == $past(pol_i[sel])); // R4
endmodule

// File: rtl/clamp_seq_gen.sv
module clamp_seq_gen
  import clamp_seq_pkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int LINE_W  = 12,
  parameter int NUM_SEQ = 4,
  parameter int NUM_RGN = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hsync_i,
  input  logic        vsync_i,
  input  logic        cfg_we_i,
  input  logic [4:0]  cfg_addr_i,
  input  logic [11:0] cfg_wdata_i,
  output logic        ob_clamp_o,
  output logic        dummy_clamp_o,
  output logic        pix_blank_o
);
  localparam int SEL_W  = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1;
  localparam int RGN_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1;
  localparam int IDX_W  = (SEL_W > RGN_W) ? SEL_W : RGN_W;
  localparam int DATA_W = 12;
  localparam int N_OUT  = 3;

  logic [PIX_W-1:0]                  pix;
  logic [LINE_W-1:0]                 line;
  logic [NUM_SEQ-1:0][PIX_W-1:0]     t1, t2;
  logic [NUM_SEQ-1:0]                pol;
  logic [NUM_RGN-1:1][LINE_W-1:0]    ccp, bcp;
  logic [NUM_RGN-1:0][SEL_W-1:0]     ob_ptr, dm_ptr, bl_ptr;
  logic [RGN_W-1:0]                  clamp_rgn, blank_rgn;
  logic [N_OUT-1:0][NUM_RGN-1:0][SEL_W-1:0] ptr_all;
  logic [N_OUT-1:0][RGN_W-1:0]       rgn_all;
  logic [N_OUT-1:0]                  pulse;

  pix_line_cnt #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hsync_i (hsync_i),
    .vsync_i (vsync_i),
    .pix_o   (pix),
    .line_o  (line)
  );

  seq_cfg_regs #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .NUM_SEQ(NUM_SEQ), .NUM_RGN(NUM_RGN),
    .IDX_W(IDX_W), .SEL_W(SEL_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i[KIND_W+IDX_W-1:0]),
    .wdata_i  (cfg_wdata_i),
    .t1_o     (t1),
    .t2_o     (t2),
    .pol_o    (pol),
    .ccp_o    (ccp),
    .bcp_o    (bcp),
    .ob_ptr_o (ob_ptr),
    .dm_ptr_o (dm_ptr),
    .bl_ptr_o (bl_ptr)
  );

  region_select #(.LINE_W(LINE_W), .NUM_RGN(NUM_RGN), .RGN_W(RGN_W)) u_clamp_rgn (
    .line_i (line),
    .cp_i   (ccp),
    .rgn_o  (clamp_rgn)
  );

  region_select #(.LINE_W(LINE_W), .NUM_RGN(NUM_RGN), .RGN_W(RGN_W)) u_blank_rgn (
    .line_i (line),
    .cp_i   (bcp),
    .rgn_o  (blank_rgn)
  );

  assign ptr_all = {bl_ptr, dm_ptr, ob_ptr};
  assign rgn_all = {blank_rgn, clamp_rgn, clamp_rgn};

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    seq_pulse #(
      .PIX_W(PIX_W), .NUM_SEQ(NUM_SEQ), .NUM_RGN(NUM_RGN),
      .SEL_W(SEL_W), .RGN_W(RGN_W)
    ) u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pix_i   (pix),
      .rgn_i   (rgn_all[o]),
      .ptr_i   (ptr_all[o]),
      .t1_i    (t1),
      .t2_i    (t2),
      .pol_i   (pol),
      .pulse_o (pulse[o])
    );
  end

  assign ob_clamp_o    = pulse[0];
  assign dummy_clamp_o = pulse[1];
  assign pix_blank_o   = pulse[2];

  AST_CLAMP_RGN_REACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_rgn != '0) |-> (line >= ccp[clamp_rgn])); // R5
  AST_BLANK_RGN_REACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_rgn != '0) |-> (line >= bcp[blank_rgn])); // R6
endmodule

// File: tb/sim_clamp_seq_gen.sv
`timescale 1ns/1ps
module sim_clamp_seq_gen;
  localparam int PW = 12;
  localparam int LW = 12;
  localparam int NS = 4;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0, vs = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [11:0] wdata = '0;
  logic ob, dm, bl;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string tag = "R9";

  always #2.5 clk = ~clk;

  clamp_seq_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .ob_clamp_o(ob), .dummy_clamp_o(dm), .pix_blank_o(bl)
  );

  // reference model built from the requirements
  logic [PW-1:0] m_t1 [NS];
  logic [PW-1:0] m_t2 [NS];
  logic          m_pol[NS];
  logic [LW-1:0] m_ccp[NR];
  logic [LW-1:0] m_bcp[NR];
  logic [1:0]    m_ob [NR];
  logic [1:0]    m_dm [NR];
  logic [1:0]    m_bs [NR];
  logic [PW-1:0] m_pix;
  logic [LW-1:0] m_line;
  logic e_ob, e_dm, e_bl;

  function automatic int rgn_of(logic [LW-1:0] ln, bit blank);
    int r = 0;
    for (int k = 1; k < NR; k++) begin
      if (ln >= (blank ? m_bcp[k] : m_ccp[k])) r = k;
    end
    return r;
  endfunction

  function automatic logic lvl(logic [1:0] s, logic [PW-1:0] p);
    return m_pol[s] ^ ((p >= m_t1[s]) && (p < m_t2[s]));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        m_t1[i] <= '0; m_t2[i] <= '0; m_pol[i] <= 1'b0;
      end
      for (int i = 0; i < NR; i++) begin
        m_ccp[i] <= '0; m_bcp[i] <= '0; m_ob[i] <= '0; m_dm[i] <= '0; m_bs[i] <= '0;
      end
      m_pix <= '0; m_line <= '0;
      e_ob <= 1'b0; e_dm <= 1'b0; e_bl <= 1'b0;
    end else begin
      e_ob <= lvl(m_ob[rgn_of(m_line, 1'b0)], m_pix);
      e_dm <= lvl(m_dm[rgn_of(m_line, 1'b0)], m_pix);
      e_bl <= lvl(m_bs[rgn_of(m_line, 1'b1)], m_pix);
      if (hs || vs) m_pix <= '0;
      else if (m_pix != '1) m_pix <= m_pix + 1'b1;
      if (vs) m_line <= '0;
      else if (hs && m_line != '1) m_line <= m_line + 1'b1;
      if (we) begin
        case (addr[4:2])
          3'd0: m_t1[addr[1:0]]  <= wdata;
          3'd1: m_t2[addr[1:0]]  <= wdata;
          3'd2: m_pol[addr[1:0]] <= wdata[0];
          3'd3: if (addr[1:0] != 0) m_ccp[addr[1:0]] <= wdata;
          3'd4: if (addr[1:0] != 0) m_bcp[addr[1:0]] <= wdata;
          3'd5: begin m_ob[addr[1:0]] <= wdata[1:0]; m_dm[addr[1:0]] <= wdata[3:2]; end
          3'd6: m_bs[addr[1:0]] <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      checks++;
      if (ob !== e_ob || dm !== e_dm || bl !== e_bl) begin
        errors++;
        $display("FAIL %s t=%0t actual ob/dm/bl=%b%b%b expected=%b%b%b",
                 tag, $time, ob, dm, bl, e_ob, e_dm, e_bl);
      end
    end
  end

  task automatic finish_sim();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [2:0] kind, input logic [1:0] idx, input logic [11:0] d);
    @(negedge clk);
    we = 1'b1; addr = {kind, idx}; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic run_line(input int len);
    @(negedge clk); hs = 1'b1;
    @(negedge clk); hs = 1'b0;
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic new_field();
    @(negedge clk); vs = 1'b1; hs = 1'b1;
    @(negedge clk); vs = 1'b0; hs = 1'b0;
  endtask

  task automatic t_reset();
    tag = "R9";
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (ob !== 1'b0 || dm !== 1'b0 || bl !== 1'b0) begin
        errors++;
        $display("FAIL R9 reset actual=%b%b%b expected=000", ob, dm, bl);
      end
    end
    rst_n = 1'b1;
    chk_on = 1'b1;
    run_line(20);
    run_line(20);
  endtask

  task automatic t_basic();
    tag = "R3";
    wr(3'd0, 2'd0, 12'd5);
    wr(3'd1, 2'd0, 12'd12);
    repeat (3) run_line(20);
    tag = "R8";
    wr(3'd2, 2'd0, 12'd1);
    repeat (2) run_line(20);
  endtask

  task automatic t_pointers();
    tag = "R7";
    wr(3'd0, 2'd1, 12'd3);  wr(3'd1, 2'd1, 12'd8);  wr(3'd2, 2'd1, 12'd0);
    wr(3'd0, 2'd2, 12'd9);  wr(3'd1, 2'd2, 12'd15); wr(3'd2, 2'd2, 12'd1);
    for (int r = 0; r < NR; r++) begin
      wr(3'd5, 2'(r), {8'd0, 2'd2, 2'd1});
      wr(3'd6, 2'(r), 12'd0);
    end
    repeat (3) run_line(20);
  endtask

  task automatic t_regions();
    tag = "R5";
    wr(3'd3, 2'd1, 12'd2); wr(3'd3, 2'd2, 12'd4); wr(3'd3, 2'd3, 12'd6);
    wr(3'd5, 2'd0, 12'h001); wr(3'd5, 2'd1, 12'h006);
    wr(3'd5, 2'd2, 12'h008); wr(3'd5, 2'd3, 12'h00E);
    new_field();
    repeat (9) run_line(20);
    tag = "R6";
    wr(3'd4, 2'd1, 12'd1); wr(3'd4, 2'd2, 12'd3); wr(3'd4, 2'd3, 12'd5);
    wr(3'd6, 2'd0, 12'd2); wr(3'd6, 2'd1, 12'd1);
    wr(3'd6, 2'd2, 12'd0); wr(3'd6, 2'd3, 12'd3);
    wr(3'd0, 2'd3, 12'd1); wr(3'd1, 2'd3, 12'd19); wr(3'd2, 2'd3, 12'd0);
    new_field();
    repeat (9) run_line(20);
  endtask

  task automatic t_no_match();
    tag = "R4";
    wr(3'd0, 2'd2, 12'd4000); wr(3'd1, 2'd2, 12'd4050);
    wr(3'd0, 2'd3, 12'd10);   wr(3'd1, 2'd3, 12'd10);
    new_field();
    repeat (8) run_line(20);
    wr(3'd1, 2'd3, 12'd6);
    new_field();
    repeat (8) run_line(20);
  endtask

  task automatic t_ignored();
    tag = "R10";
    wr(3'd7, 2'd0, 12'hFFF);
    wr(3'd7, 2'd2, 12'h000);
    wr(3'd3, 2'd0, 12'd7);
    wr(3'd4, 2'd0, 12'd7);
    new_field();
    repeat (8) run_line(20);
  endtask

  task automatic t_counters();
    tag = "R2";
    new_field();
    run_line(15);
    @(negedge clk); vs = 1'b1; hs = 1'b1;
    @(negedge clk); vs = 1'b0; hs = 1'b0;
    repeat (4) run_line(15);
    @(negedge clk); vs = 1'b1;
    @(negedge clk); vs = 1'b0;
    repeat (14) @(negedge clk);
    run_line(15);
    tag = "R1";
    wr(3'd0, 2'd0, 12'd4090); wr(3'd1, 2'd0, 12'd4095); wr(3'd2, 2'd0, 12'd0);
    for (int r = 0; r < NR; r++) wr(3'd5, 2'(r), 12'h000);
    run_line(4110);
    run_line(10);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_sim();
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_pointers();
    t_regions();
    t_no_match();
    t_ignored();
    t_counters();
    repeat (2) @(negedge clk);
    finish_sim();
  end
endmodule